// File: doc/BRIEF.md
# Zero-Run Escape Decompressor

This block restores a configuration bitstream that was stored with a simple zero-run code. Compressed bytes enter on a valid/ready stream and decompressed bytes leave on a second valid/ready stream. Both streams carry an end-of-stream flag, and the output keeps the same byte order as the input. The block sits between a memory fetch engine and whatever drives the device configuration port.

The code uses one reserved escape byte, 0x55. When the escape byte is followed by a count from 2 to 255, the pair stands for that many 0x00 bytes. When the escape byte is followed by 0x00, the pair stands for one literal 0x55. Every other byte is copied through unchanged, and this includes a single 0x00. Two malformed inputs raise a sticky format-error flag. The first is a count of 1, which still produces one zero byte. The second is an escape byte that is the final byte of the stream, which produces nothing.

The controller has three states:
- PASS copies literals to the output. An escape byte moves it to COUNT.
- COUNT decodes the count byte. It returns to PASS for a count of 0 or 1, and moves to RUN for a count of 2 or more.
- RUN emits the remaining zeros with input ready held low. It returns to PASS as it loads the last zero.

Each output byte is loaded into one output register, one cycle after the input beat or output slot that produces it.

Top module: `zrun_expand`

## Requirements
- R1: After reset, out_valid and fmt_err are 0 and in_ready is 1.
- R2: An input byte other than 0x55, including a lone 0x00, appears unchanged as exactly one output byte, in input order.
- R3: The pair 0x55, nn with nn from 2 to 255 produces exactly nn output bytes of 0x00.
- R4: The pair 0x55, 0x00 produces exactly one output byte 0x55.
- R5: The pair 0x55, 0x01 produces one output byte 0x00 and sets fmt_err.
- R6: An escape byte received with in_last high produces no output byte and sets fmt_err.
- R7: While zeros from a run are still to be loaded, in_ready is 0.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values, and no byte is lost or duplicated.
- R9: out_last is 1 only on the final output byte produced by an input byte that carried in_last. For a run pair, this is the last zero of the run.
- R10: Once set, fmt_err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Compressed byte |
| in_valid | input | 1 | Compressed byte present |
| in_last | input | 1 | Compressed byte ends the stream |
| in_ready | output | 1 | Block accepts the compressed byte |
| out_data | output | 8 | Decompressed byte |
| out_valid | output | 1 | Decompressed byte present |
| out_last | output | 1 | Decompressed byte ends the stream |
| out_ready | input | 1 | Sink accepts the decompressed byte |
| fmt_err | output | 1 | Sticky malformed-stream flag |

## Verification
A state register stuck in COUNT or RUN shows at the ports within one beat. A following literal either vanishes or turns into zeros, so the next output compare fails. An off-by-one in the run counter adds or drops a zero at the run's end, and the model detects it on the first byte after the run. A RUN state that leaves early raises in_ready while the model still expects pending zeros, and the per-clock check catches that in the same cycle. Random output stalls show whether held beats stay stable and are delivered exactly once.

// File: rtl/zrun_pkg.sv
package zrun_pkg;
    typedef enum logic [1:0] {
        S_PASS  = 2'd0,
        S_COUNT = 2'd1,
        S_RUN   = 2'd2
    } zrun_state_t;
endpackage

// File: rtl/zrun_count.sv
module zrun_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_last,
    input  logic         step,
    output logic         is_one,
    output logic         run_last
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            run_last <= 1'b0;
        end else if (load) begin
            remain   <= load_val;
            run_last <= load_last;
        end else if (step) begin
            remain   <= remain - W'(1);
        end
    end

    assign is_one = (remain == W'(1));

    // R3: a zero is never taken from an empty run
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> remain != '0);
endmodule

// File: rtl/zrun_slot.sv
module zrun_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_last,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_last,
    output logic         free
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
            out_last  <= load_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8: a stalled beat is held unchanged
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/zrun_expand.sv
module zrun_expand #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  ESC_CODE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic              fmt_err
);
    import zrun_pkg::*;

    localparam logic [DATA_W-1:0] ESC = DATA_W'(ESC_CODE);

    zrun_state_t       state, nxt;
    logic              free, acc;
    logic              ld, ld_last, cnt_load, cnt_step, err_set;
    logic [DATA_W-1:0] ld_data;
    logic              is_one, run_last;

    zrun_slot #(.W(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_data (ld_data),
        .load_last (ld_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .free      (free)
    );

    zrun_count #(.W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (in_data - DATA_W'(1)),
        .load_last (in_last),
        .step      (cnt_step),
        .is_one    (is_one),
        .run_last  (run_last)
    );

    assign in_ready = (state != S_RUN) && free;
    assign acc      = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_PASS;
            fmt_err <= 1'b0;
        end else begin
            state <= nxt;
            if (err_set) fmt_err <= 1'b1;
        end
    end

    always_comb begin
        nxt      = state;
        ld       = 1'b0;
        ld_data  = '0;
        ld_last  = 1'b0;
        cnt_load = 1'b0;
        cnt_step = 1'b0;
        err_set  = 1'b0;
        unique case (state)
            S_PASS: begin
                if (acc) begin
                    if (in_data == ESC) begin
                        if (in_last) err_set = 1'b1;
                        else         nxt     = S_COUNT;
                    end else begin
                        ld      = 1'b1;
                        ld_data = in_data;
                        ld_last = in_last;
                    end
                end
            end
            S_COUNT: begin
                if (acc) begin
                    ld  = 1'b1;
                    nxt = S_PASS;
                    if (in_data == '0) begin
                        ld_data = ESC;
                        ld_last = in_last;
                    end else if (in_data == DATA_W'(1)) begin
                        ld_last = in_last;
                        err_set = 1'b1;
                    end else begin
                        cnt_load = 1'b1;
                        nxt      = S_RUN;
                    end
                end
            end
            S_RUN: begin
                if (free) begin
                    ld       = 1'b1;
                    cnt_step = 1'b1;
                    ld_last  = run_last && is_one;
                    if (is_one) nxt = S_PASS;
                end
            end
            default: nxt = S_PASS;
        endcase
    end

    // R2: a literal is the next byte presented
    p_literal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == S_PASS && in_data != ESC) |=> (out_valid && out_data == $past(in_data)));

    // R3: only zeros leave while a run is active
    p_run_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && out_valid) |-> out_data == '0);

    // R6: an escape that ends the stream flags an error
    p_lone_esc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == S_PASS && in_data == ESC && in_last) |=> fmt_err);

    // R10: the error flag never clears
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);
endmodule

// File: tb/zrun_expand_test.sv
module zrun_expand_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;
    logic       out_ready = 1'b1;
    logic       fmt_err;

    always #10 clk = ~clk;

    zrun_expand uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .fmt_err(fmt_err)
    );

    int   compared = 0;
    int   mismatched = 0;
    logic [8:0] expq[$];
    int   model_run = 0;
    bit   model_esc = 0;
    bit   exp_err = 0;
    bit   held = 0;
    logic [8:0] held_val;
    bit   monitor_on = 0;
    bit   stall_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    bit   done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= stall_mode ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (monitor_on) begin
            // R7: input stalled while run zeros remain
            if (model_run > 0) check(!in_ready, "R7", in_ready, 0);
            // R5 R6 R10: error flag matches model
            check(fmt_err == exp_err, "R10", fmt_err, exp_err);
            // R8: held beat stable
            if (held) check(out_valid && {out_last, out_data} == held_val, "R8", {out_valid, out_last, out_data}, {1'b1, held_val});
            held = out_valid && !out_ready;
            held_val = {out_last, out_data};
            if (out_valid && out_ready) begin
                if (expq.size() == 0) check(0, "R2", out_data, 0);
                else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    check({out_last, out_data} == e, "R9", {out_last, out_data}, e);
                end
                if (model_run > 0) model_run--;
            end
            if (in_valid && in_ready) begin
                if (!model_esc) begin
                    if (in_data == 8'h55) begin
                        if (in_last) exp_err = 1;
                        else model_esc = 1;
                    end else expq.push_back({in_last, in_data});
                end else begin
                    model_esc = 0;
                    if (in_data == 8'h00) expq.push_back({in_last, 8'h55});
                    else if (in_data == 8'h01) begin
                        expq.push_back({in_last, 8'h00});
                        exp_err = 1;
                    end else begin
                        for (int i = 0; i < in_data; i++)
                            expq.push_back({(in_last && i == in_data - 1), 8'h00});
                        model_run = in_data - 1;
                    end
                end
            end
        end
    end

    task automatic send(input logic [7:0] b, input bit l);
        in_data = b; in_last = l; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk); #1;
                break;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (expq.size() != 0 || out_valid); i++) @(posedge clk);
        #1;
        check(expq.size() == 0, "R3", expq.size(), 0);
    endtask

    task automatic do_reset();
        monitor_on = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        expq.delete(); model_run = 0; model_esc = 0; exp_err = 0; held = 0;
        @(negedge clk);
        // R1: reset state
        check(!out_valid && !fmt_err && in_ready, "R1", {out_valid, fmt_err, in_ready}, 3'b001);
        monitor_on = 1;
    endtask

    task automatic pattern();
        send(8'h12, 0); send(8'h00, 0); send(8'hFF, 0);          // R2
        send(8'h55, 0); send(8'h00, 0);                          // R4
        send(8'h55, 0); send(8'h02, 0);                          // R3
        send(8'h00, 0); send(8'hAA, 0);
        send(8'h55, 0); send(8'h05, 0);
        send(8'h55, 0); send(8'hFF, 0);
        send(8'h55, 0); send(8'h04, 1);                          // R9
        drain();
    endtask

    initial begin
        do_reset();
        pattern();
        stall_mode = 1;
        pattern();
        stall_mode = 0;
        // R5 and R10: count of one, then more traffic
        send(8'h55, 0); send(8'h01, 0);
        send(8'h33, 0); send(8'h55, 0); send(8'h03, 1);
        drain();
        check(fmt_err == 1'b1, "R5", fmt_err, 1);
        // R6: escape as last byte
        do_reset();
        send(8'h44, 0);
        send(8'h55, 1);
        drain();
        repeat (3) @(posedge clk);
        #1;
        check(fmt_err && !out_valid, "R6", {fmt_err, out_valid}, 2'b10);
        send(8'h55, 0); send(8'h00, 1);
        drain();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule